// File: doc/BRIEF.md
# UART Transmit-Ready Interrupt Generator

This block raises the transmit-ready interrupt request for one UART channel. It watches the transmit FIFO fill level against a programmable trigger level. In single-register mode it watches for the holding register becoming empty. A rising condition is turned into an event, the event is held in a pending flag, and the pending flag, gated by the interrupt enable, drives a registered request output.

In FIFO mode a drain of the FIFO gives two events: one when the fill level first drops below the trigger level, and one when the FIFO reaches zero. With automatic RS-485 direction control on, the zero-level event is held back until the transmit shift register has also gone idle. This keeps the line driver enabled until the last bit has left.

Software clears the pending request either by reading the interrupt status register or by writing a new character into the transmit holding register. The block only sees these as single-cycle strobes. Priority against other interrupt sources is handled elsewhere.

Top module: `tx_ready_irq`

## Requirements
- R1: While `rst` is high, and afterwards while `irq_en` is 0, `txrdy_irq` is 0. Reset clears the recorded condition history, so a condition that is already true on the first clock after reset counts as a new event.
- R2: With `fifo_mode` = 0, an event occurs when `fifo_level` goes from nonzero to 0 (holding register becomes empty).
- R3: With `fifo_mode` = 1, an event occurs when `fifo_level` goes from a value not below `trig_level` to a value below it.
- R4: With `fifo_mode` = 1, a second event occurs when `fifo_level` becomes 0, even after the trigger event was cleared.
- R5: With `fifo_mode` = 1 and `rs485_auto` = 1, the empty event needs both `fifo_level` = 0 and `shift_busy` = 0. It fires when the later of the two becomes true.
- R6: A cycle with `isr_rd` = 1 and no new event clears the pending request.
- R7: A cycle with `thr_wr` = 1 and no new event clears the pending request.
- R8: Events come from transitions only. Conditions that stay true do not raise the request again after it has been cleared.
- R9: `txrdy_irq` is the pending flag ANDed with `irq_en`. Events that arrive while `irq_en` = 0 stay pending and appear once `irq_en` is set. Dropping `irq_en` hides the request without clearing it.
- R10: If a clear strobe and a new event fall in the same cycle, the event wins and the request stays pending.
- R11: `txrdy_irq` reflects the inputs sampled at a clock edge immediately after that edge (one register stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | 1 = FIFO mode, 0 = single holding register |
| rs485_auto | input | 1 | Automatic RS-485 direction control enable |
| shift_busy | input | 1 | Transmit shift register still sending |
| fifo_level | input | CNT_W | Transmit FIFO fill count |
| trig_level | input | CNT_W | Programmed transmit trigger level |
| irq_en | input | 1 | Transmit-ready interrupt enable |
| thr_wr | input | 1 | Strobe: write to transmit holding register |
| isr_rd | input | 1 | Strobe: read of interrupt status register |
| txrdy_irq | output | 1 | Registered transmit-ready interrupt request |

## Verification
A corrupted condition history shows up at the output within one clock. The request either fires while the level is unchanged, or it misses a threshold or empty crossing. Both appear right after the step in which the level moves. A pending flag stuck high or low shows up on the first cycle after a clear strobe or after an event. The sweep drives every pair of consecutive fill levels against every trigger level in both modes, with and without RS-485 control and shift activity. This exposes any wrong comparison or edge term in a single step.

// File: rtl/txr_pkg.sv
package txr_pkg;
  // Conditions whose rising edges produce transmit-ready events
  typedef struct packed {
    logic below;   // fill level under the trigger
    logic drained; // FIFO empty (and shifter idle under RS-485 control)
    logic hold_mt; // holding register empty (single-register mode)
  } txr_cond_t;
endpackage

// File: rtl/txr_event_detect.sv
module txr_event_detect
  import txr_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_mode,
  input  logic             rs485_auto,
  input  logic             shift_busy,
  input  logic [CNT_W-1:0] fifo_level,
  input  logic [CNT_W-1:0] trig_level,
  output logic             evt_o
);
  txr_cond_t cond_d, cond_q;
  logic      lvl_zero;

  always_comb begin
    lvl_zero       = (fifo_level == '0);
    cond_d.below   = (fifo_level < trig_level);
    cond_d.drained = lvl_zero && !(rs485_auto && shift_busy);
    cond_d.hold_mt = lvl_zero;
  end

  // History resets to all-false: a condition true at reset exit is an event
  always_ff @(posedge clk) begin
    if (rst) cond_q <= '0;
    else     cond_q <= cond_d;
  end

  always_comb begin
    if (fifo_mode)
      evt_o = (cond_d.below && !cond_q.below) || (cond_d.drained && !cond_q.drained);
    else
      evt_o = cond_d.hold_mt && !cond_q.hold_mt;
  end

  // R8
  no_retrigger_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(fifo_level) && $stable(trig_level) && $stable(fifo_mode)
     && $stable(rs485_auto) && $stable(shift_busy)) |-> !evt_o);

  // R5
  rs485_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_mode && rs485_auto && shift_busy && evt_o) |-> (fifo_level < trig_level));
endmodule

// File: rtl/txr_req_latch.sv
module txr_req_latch (
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  input  logic clr_i,
  input  logic en_i,
  output logic irq_o
);
  logic pend_q, pend_d;

  always_comb begin
    if (evt_i)      pend_d = 1'b1;   // new event beats a simultaneous clear
    else if (clr_i) pend_d = 1'b0;
    else            pend_d = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_o  <= pend_d && en_i;
    end
  end

  // R9
  en_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !irq_o);

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !evt_i) |=> !irq_o);

  // R10
  event_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_i && en_i) |=> irq_o);
endmodule

// File: rtl/tx_ready_irq.sv
module tx_ready_irq #(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_mode,
  input  logic             rs485_auto,
  input  logic             shift_busy,
  input  logic [CNT_W-1:0] fifo_level,
  input  logic [CNT_W-1:0] trig_level,
  input  logic             irq_en,
  input  logic             thr_wr,
  input  logic             isr_rd,
  output logic             txrdy_irq
);
  logic evt;
  logic clr;

  assign clr = thr_wr || isr_rd;

  txr_event_detect #(.CNT_W(CNT_W)) det_i (
    .clk        (clk),
    .rst        (rst),
    .fifo_mode  (fifo_mode),
    .rs485_auto (rs485_auto && fifo_mode),
    .shift_busy (shift_busy),
    .fifo_level (fifo_level),
    .trig_level (trig_level),
    .evt_o      (evt)
  );

  txr_req_latch lat_i (
    .clk   (clk),
    .rst   (rst),
    .evt_i (evt),
    .clr_i (clr),
    .en_i  (irq_en),
    .irq_o (txrdy_irq)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !txrdy_irq);
endmodule

// File: tb/tx_ready_irq_tb.sv
module tx_ready_irq_tb_top;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst, fifo_mode, rs485_auto, shift_busy, irq_en, thr_wr, isr_rd;
  logic [CNT_W-1:0] fifo_level, trig_level;
  logic txrdy_irq;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  tx_ready_irq #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .rs485_auto(rs485_auto),
    .shift_busy(shift_busy), .fifo_level(fifo_level), .trig_level(trig_level),
    .irq_en(irq_en), .thr_wr(thr_wr), .isr_rd(isr_rd), .txrdy_irq(txrdy_irq)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic exp);
    checks++;
    if (txrdy_irq !== exp) begin
      fails++;
      $display("FAIL %s: txrdy_irq=%b expected %b", tag, txrdy_irq, exp);
    end
  endtask

  task automatic clear_rd();
    isr_rd = 1'b1; step(); isr_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; fifo_mode = 1'b0; rs485_auto = 1'b0; shift_busy = 1'b0;
    irq_en = 1'b1; thr_wr = 1'b0; isr_rd = 1'b0;
    fifo_level = '0; trig_level = CNT_W'(4);
    @(negedge clk); step(); step();
    check("R1 in reset", 1'b0);
    irq_en = 1'b0; rst = 1'b0;
    step(); step();
    check("R1 disabled after reset", 1'b0);
    irq_en = 1'b1; step();
    check("R9 latched while disabled", 1'b1);
    irq_en = 1'b0; step();
    check("R9 masked by enable", 1'b0);
    irq_en = 1'b1; step();
    check("R9 pending kept", 1'b1);
    clear_rd();
    check("R6 status read clears", 1'b0);
    fifo_level = CNT_W'(1); step();
    check("R2 not empty", 1'b0);
    fifo_level = '0; step();
    check("R11 R2 holding empty", 1'b1);
    thr_wr = 1'b1; step(); thr_wr = 1'b0;
    check("R7 write clears", 1'b0);
    // FIFO mode
    fifo_mode = 1'b1; fifo_level = CNT_W'(8); step(); step(); clear_rd();
    check("R6 FIFO idle", 1'b0);
    fifo_level = CNT_W'(5); step();
    check("R3 above trigger", 1'b0);
    fifo_level = CNT_W'(3); step();
    check("R3 trigger crossing", 1'b1);
    clear_rd();
    fifo_level = CNT_W'(2); step(); step(); step();
    check("R8 no re-raise below trigger", 1'b0);
    fifo_level = '0; step();
    check("R4 empty event", 1'b1);
    clear_rd(); step();
    check("R8 stays empty", 1'b0);
    // auto RS-485
    rs485_auto = 1'b1; fifo_level = CNT_W'(8); step(); shift_busy = 1'b1; step(); clear_rd();
    fifo_level = CNT_W'(3); step();
    check("R5 trigger still fires", 1'b1);
    clear_rd();
    fifo_level = '0; step();
    check("R5 held while shifting", 1'b0);
    step();
    check("R5 still held", 1'b0);
    shift_busy = 1'b0; step();
    check("R5 fires at shifter idle", 1'b1);
    // clear and event together
    clear_rd(); fifo_level = CNT_W'(8); step(); clear_rd();
    fifo_level = CNT_W'(3); isr_rd = 1'b1; step(); isr_rd = 1'b0;
    check("R10 event beats clear", 1'b1);
    thr_wr = 1'b1; fifo_level = '0; step(); thr_wr = 1'b0;
    check("R10 empty beats write", 1'b1);

    // Exhaustive sweep of level pairs
    for (int m = 0; m < 2; m++)
      for (int r = 0; r < 2; r++)
        for (int b = 0; b < 2; b++)
          for (int t = 1; t <= DEPTH; t++)
            for (int a = 0; a <= DEPTH; a++)
              for (int n = 0; n <= DEPTH; n++) begin
                logic exp, emp_a, emp_b;
                fifo_mode = m[0]; rs485_auto = r[0]; shift_busy = b[0];
                trig_level = CNT_W'(t); fifo_level = CNT_W'(a);
                step(); step(); clear_rd();
                fifo_level = CNT_W'(n); step();
                emp_a = (a == 0) && !(r == 1 && b == 1);
                emp_b = (n == 0) && !(r == 1 && b == 1);
                if (m == 1)
                  exp = ((n < t) && !(a < t)) || (emp_b && !emp_a);
                else
                  exp = (n == 0) && (a != 0);
                check(m == 1 ? "R3/R4/R5 sweep" : "R2 sweep", exp);
              end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule